// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Engine

This block is the memory-side mover for an audio FIFO. It walks a circular buffer in system memory in fixed-size bursts. Each burst goes out as a request with an address and finishes when the memory side acknowledges it. The buffer is bounded by a base address and a last-burst address. The last-burst address is the first byte of the final burst, not the byte after the buffer. After the burst at that address, the next burst goes back to the base.

A block counter counts completed bursts against a programmed period length. When a period completes, it raises a repeating interrupt. A second interrupt source marks each wrap of the buffer. Software drives the engine through eight word registers:
- an enable bit;
- per-source interrupt enables;
- clear bits that must be set and then released;
- a status word whose content is chosen by a select field.

A build option adds a separate first-burst address, so a stream can begin part-way into the buffer.

Top module: `ring_dma_top`

## Requirements
- R1: Each burst request carries an address one burst size (BURST_BYTES, default 8) above the previous completed burst, unless R2 or R9 applies.
- R2: The burst that follows a completed burst at the last-burst address (register 3) uses the base address (register 2). Completing a burst at the last-burst address sets pending bit 1 (wrap).
- R3: Pending bit 0 (block) sets each time the number of completed bursts reaches the period value (register 5). The count runs across buffer wraps and restarts from zero after each event. Writing register 5 zeroes the count. A period of 0 never raises the event.
- R4: Clearing the enable (register 0 bit 0) lets a burst already requested finish, and then no new request is made. The next-burst pointer holds its value, and setting the enable again resumes from it.
- R5: Once mem_req is high, it stays high with mem_addr unchanged until the cycle in which mem_ack is sampled high.
- R6: Pending flags (register 6, bit 0 block, bit 1 wrap) set whether or not their enables (register 0 bits 9:8) are on. irq is high exactly when some pending flag is set and its enable is set.
- R7: While a clear bit (register 1 bits 1:0, same order as pending) holds 1, the matching pending flag reads 0 and cannot set. After the clear bit is written back to 0, the flag can latch again.
- R8: Register 7 shows what the select field (register 1 bits 5:4) chooses:
  - 0: the next-burst pointer;
  - 1: the block count;
  - 2: the address of the burst in flight (0 when none is in flight);
  - 3: zero.
- R9: With HAS_INIT=1, the first burst after reset, or after a write to register 2 or register 4, uses the first-burst address (register 4). Later wraps still return to the base.
- R10: After reset, mem_req and irq are low, pending flags read 0, and the pointer reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Burst start address |
| mem_ack | input | 1 | Burst completion from memory side |
| irq | output | 1 | Interrupt line |

## Verification
The ring walk is run with several period lengths: 2, 3 and 1 bursts, and a period of 0. The period of 3 does not divide the four-burst ring, so the block count has to carry across the wrap; this separates a counter that resets at the wrap from one that does not. Runs that start from the first-burst address check that the first address comes from register 4 and that later wraps still return to the base. The pause run disables the engine with a burst in flight and re-enables it later, which separates completing the in-flight burst and holding the pointer from dropping the burst or rewinding. Clear-held and enable-off runs check that masking and clearing act on different points of the pending path.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
   // register word indices
   localparam logic [2:0] RA_CTL  = 3'd0;
   localparam logic [2:0] RA_ACK  = 3'd1;
   localparam logic [2:0] RA_BASE = 3'd2;
   localparam logic [2:0] RA_LAST = 3'd3;
   localparam logic [2:0] RA_INIT = 3'd4;
   localparam logic [2:0] RA_PER  = 3'd5;
   localparam logic [2:0] RA_PEND = 3'd6;
   localparam logic [2:0] RA_STAT = 3'd7;

   localparam int NSRC      = 2;
   localparam int SRC_BLOCK = 0;
   localparam int SRC_WRAP  = 1;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_INFL = 2'd2,
      SEL_NONE = 2'd3
   } stat_sel_e;
endpackage

// File: rtl/ring_dma_agen.sv
module ring_dma_agen #(
   parameter int AW          = 32,
   parameter int BURST_BYTES = 8,
   parameter int HAS_INIT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          rearm,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] last,
   input  logic [AW-1:0] init,
   input  logic          ack,
   output logic          req,
   output logic [AW-1:0] req_addr,
   output logic [AW-1:0] ptr,
   output logic          done,
   output logic          wrapped
);
   localparam logic [AW-1:0] STEP = AW'(BURST_BYTES);

   logic          busy;
   logic          fresh;
   logic [AW-1:0] first_addr;

   generate
      if (HAS_INIT != 0) begin : g_init
         assign first_addr = init;
      end else begin : g_noinit
         logic unused_init;
         assign first_addr  = base;
         assign unused_init = ^init;
      end
   endgenerate

   assign req     = busy;
   assign done    = busy & ack;
   assign wrapped = done & (req_addr == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         fresh    <= 1'b1;
         ptr      <= '0;
         req_addr <= '0;
      end else begin
         if (done) begin
            busy <= 1'b0;
            ptr  <= wrapped ? base : req_addr + STEP;
         end else if (!busy && en) begin
            busy     <= 1'b1;
            req_addr <= fresh ? first_addr : ptr;
            fresh    <= 1'b0;
         end
         if (rearm) fresh <= 1'b1;
      end
   end

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(req_addr)));

   // R4
   idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !en) |=> !req);

   // R2
   wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack && req_addr == last) |=> (ptr == $past(base)));
endmodule

// File: rtl/ring_dma_irq.sv
module ring_dma_irq #(
   parameter int CW   = 16,
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            done,
   input  logic            wrapped,
   input  logic [CW-1:0]   period,
   input  logic            period_wr,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] ie,
   output logic [NSRC-1:0] pend,
   output logic [CW-1:0]   blk_cnt,
   output logic            irq
);
   logic            blk_evt;
   logic [NSRC-1:0] ev;

   assign blk_evt = done && (period != '0) && (blk_cnt == period - 1'b1);

   always_comb begin
      ev    = '0;
      ev[0] = blk_evt;
      ev[1] = wrapped;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_cnt <= '0;
      end else if (period_wr) begin
         blk_cnt <= '0;
      end else if (done && period != '0) begin
         blk_cnt <= blk_evt ? '0 : blk_cnt + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (clr[i]) pend[i] <= 1'b0;
            else if (ev[i])  pend[i] <= 1'b1;
         end
      end
   endgenerate

   assign irq = |(pend & ie);

   // R7
   clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr) |=> ((pend & $past(clr)) == '0));

   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev & ~clr) != '0) |=> ((pend & $past(ev & ~clr)) == $past(ev & ~clr)));

   // R3
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_wr |=> (blk_cnt == '0));
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
   import ring_dma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [2:0]      addr,
   input  logic [AW-1:0]   wdata,
   output logic [AW-1:0]   rdata,
   output logic            dma_en,
   output logic [NSRC-1:0] ie,
   output logic [NSRC-1:0] clr,
   output logic [AW-1:0]   base,
   output logic [AW-1:0]   last,
   output logic [AW-1:0]   init,
   output logic [CW-1:0]   period,
   output logic            period_wr,
   output logic            rearm,
   input  logic [NSRC-1:0] pend,
   input  logic [AW-1:0]   ptr,
   input  logic [CW-1:0]   blk_cnt,
   input  logic            req,
   input  logic [AW-1:0]   req_addr
);
   stat_sel_e sel;
   logic [AW-1:0] stat_word;

   assign period_wr = we && (addr == RA_PER);
   assign rearm     = we && (addr == RA_BASE || addr == RA_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_en <= 1'b0;
         ie     <= '0;
         clr    <= '0;
         sel    <= SEL_PTR;
         base   <= '0;
         last   <= '0;
         init   <= '0;
         period <= '0;
      end else if (we) begin
         case (addr)
            RA_CTL: begin
               dma_en <= wdata[0];
               ie     <= wdata[8 +: NSRC];
            end
            RA_ACK: begin
               clr <= wdata[0 +: NSRC];
               sel <= stat_sel_e'(wdata[5:4]);
            end
            RA_BASE: base   <= wdata;
            RA_LAST: last   <= wdata;
            RA_INIT: init   <= wdata;
            RA_PER:  period <= wdata[CW-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_PTR:  stat_word = ptr;
         SEL_CNT:  stat_word = {{(AW-CW){1'b0}}, blk_cnt};
         SEL_INFL: stat_word = req ? req_addr : '0;
         default:  stat_word = '0;
      endcase
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CTL:  begin rdata[0] = dma_en; rdata[8 +: NSRC] = ie; end
         RA_ACK:  begin rdata[0 +: NSRC] = clr; rdata[5:4] = sel; end
         RA_BASE: rdata = base;
         RA_LAST: rdata = last;
         RA_INIT: rdata = init;
         RA_PER:  rdata = {{(AW-CW){1'b0}}, period};
         RA_PEND: rdata[0 +: NSRC] = pend;
         default: rdata = stat_word;
      endcase
   end
endmodule

// File: rtl/ring_dma_top.sv
module ring_dma_top
   import ring_dma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 16,
   parameter int BURST_BYTES = 8,
   parameter int HAS_INIT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   output logic          irq
);
   generate
      if (AW < 16 || CW >= AW || CW < 1) begin : g_bad_width
         $error("ring_dma_top: need AW >= 16 and 1 <= CW < AW");
      end
      if (BURST_BYTES < 1 || (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_bad_burst
         $error("ring_dma_top: BURST_BYTES must be a power of two");
      end
   endgenerate

   logic            dma_en, period_wr, rearm, done, wrapped;
   logic [NSRC-1:0] ie, clr, pend;
   logic [AW-1:0]   base, last, init, ptr;
   logic [CW-1:0]   period, blk_cnt;

   ring_dma_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .dma_en(dma_en), .ie(ie),
      .clr(clr), .base(base), .last(last), .init(init), .period(period),
      .period_wr(period_wr), .rearm(rearm), .pend(pend), .ptr(ptr),
      .blk_cnt(blk_cnt), .req(mem_req), .req_addr(mem_addr)
   );

   ring_dma_agen #(.AW(AW), .BURST_BYTES(BURST_BYTES), .HAS_INIT(HAS_INIT)) u_agen (
      .clk(clk), .rst_n(rst_n), .en(dma_en), .rearm(rearm), .base(base),
      .last(last), .init(init), .ack(mem_ack), .req(mem_req),
      .req_addr(mem_addr), .ptr(ptr), .done(done), .wrapped(wrapped)
   );

   ring_dma_irq #(.CW(CW), .NSRC(NSRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .done(done), .wrapped(wrapped),
      .period(period), .period_wr(period_wr), .clr(clr), .ie(ie),
      .pend(pend), .blk_cnt(blk_cnt), .irq(irq)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !irq));
endmodule

// File: tb/sim_ring_dma_top.sv
`timescale 1ns/1ps
module sim_ring_dma_top;
   localparam logic [2:0] A_CTL = 3'd0, A_ACK = 3'd1, A_BASE = 3'd2, A_LAST = 3'd3,
                          A_INIT = 3'd4, A_PER = 3'd5, A_PEND = 3'd6, A_STAT = 3'd7;
   localparam logic [31:0] STEP = 32'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench model state
   logic [31:0] m_base = '0, m_last = '0, m_init = '0, m_next = '0;
   int          m_per = 0, m_cnt = 0;
   logic [1:0]  m_pend = '0, m_clr = '0, m_ie = '0;
   bit          m_fresh = 1;

   always #4 clk = ~clk;

   ring_dma_top u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
   );

   task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", msg, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      @(negedge clk);
      case (a)
         A_CTL:  m_ie = d[9:8];
         A_ACK:  begin m_clr = d[1:0]; m_pend = m_pend & ~m_clr; end
         A_BASE: begin m_base = d; m_fresh = 1; end
         A_LAST: m_last = d;
         A_INIT: begin m_init = d; m_fresh = 1; end
         A_PER:  begin m_per = int'(d[15:0]); m_cnt = 0; end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic serve_next(input string tag);
      logic [31:0] exp;
      logic [31:0] v;
      logic [1:0]  ev;
      int w;
      exp = m_fresh ? m_init : m_next;
      w = 0;
      while (!mem_req && w < 40) begin @(negedge clk); w++; end
      chk(mem_req === 1'b1, {tag, " request present"}, 32'(mem_req), 32'd1);
      chk(mem_addr === exp, {tag, " burst address"}, mem_addr, exp);
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      ev = '0;
      if (m_per != 0) begin
         if (m_cnt == m_per - 1) begin m_cnt = 0; ev[0] = 1'b1; end
         else m_cnt++;
      end
      ev[1] = (exp == m_last);
      m_pend = m_pend | (ev & ~m_clr);
      m_fresh = 0;
      m_next = (exp == m_last) ? m_base : exp + STEP;
      rd(A_PEND, v);
      chk(v[1:0] === m_pend, {tag, " R6 pending flags"}, v, 32'(m_pend));
      chk(irq === |(m_pend & m_ie), {tag, " R6 irq line"}, 32'(irq), 32'(|(m_pend & m_ie)));
   endtask

   task automatic halt(input string tag);
      wr(A_CTL, {22'd0, m_ie, 8'd0});
      serve_next({tag, " R4 drain"});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk(mem_req === 1'b0, "R10 req after reset", 32'(mem_req), 0);
      chk(irq === 1'b0, "R10 irq after reset", 32'(irq), 0);
      rd(A_PEND, v);
      chk(v === 0, "R10 pending after reset", v, 0);
      rd(A_STAT, v);
      chk(v === 0, "R10 pointer after reset", v, 0);
   endtask

   task automatic t_ring;
      logic [31:0] v;
      wr(A_BASE, 32'h1000);
      wr(A_LAST, 32'h1018);
      wr(A_INIT, 32'h1000);
      wr(A_PER, 32'd2);
      wr(A_CTL, 32'h101);
      for (int i = 0; i < 6; i++) serve_next("R1 R2 R3 ring");
      rd(A_STAT, v);
      chk(v === m_next, "R8 sel 0 pointer", v, m_next);
      wr(A_ACK, 32'h10);
      rd(A_STAT, v);
      chk(v === 32'(m_cnt), "R8 sel 1 block count", v, 32'(m_cnt));
      wr(A_ACK, 32'h20);
      rd(A_STAT, v);
      chk(v === m_next, "R8 sel 2 in-flight address", v, m_next);
      wr(A_ACK, 32'h30);
      rd(A_STAT, v);
      chk(v === 0, "R8 sel 3 zero", v, 0);
      wr(A_ACK, 32'h00);
   endtask

   task automatic t_pause;
      logic [31:0] v;
      logic [31:0] held;
      wr(A_CTL, 32'h100);
      chk(mem_req === 1'b1, "R4 in-flight burst kept", 32'(mem_req), 1);
      chk(mem_addr === m_next, "R5 address held while waiting", mem_addr, m_next);
      serve_next("R4 finish in-flight");
      held = m_next;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(mem_req === 1'b0, "R4 no request while disabled", 32'(mem_req), 0);
      end
      rd(A_STAT, v);
      chk(v === held, "R4 pointer held", v, held);
      wr(A_CTL, 32'h101);
      serve_next("R4 resume");
   endtask

   task automatic t_clear;
      wr(A_ACK, 32'h3);
      chk(irq === 1'b0, "R7 irq after clear", 32'(irq), 0);
      serve_next("R7 clear held");
      serve_next("R7 clear held");
      serve_next("R7 clear held");
      wr(A_ACK, 32'h0);
      serve_next("R7 after release");
      serve_next("R7 after release");
   endtask

   task automatic t_init;
      halt("init");
      wr(A_ACK, 32'h3);
      wr(A_ACK, 32'h0);
      wr(A_INIT, 32'h1010);
      wr(A_PER, 32'd3);
      wr(A_CTL, 32'h101);
      for (int i = 0; i < 7; i++) serve_next("R9 R3 first address and count across wrap");
   endtask

   task automatic t_poll;
      halt("poll");
      wr(A_ACK, 32'h3);
      wr(A_ACK, 32'h0);
      wr(A_PER, 32'd1);
      wr(A_CTL, 32'h001);
      serve_next("R6 enable off");
      chk(irq === 1'b0, "R6 irq masked", 32'(irq), 0);
      chk(m_pend[0] === 1'b1, "R6 model pending set", 32'(m_pend), 1);
      wr(A_CTL, 32'h301);
      chk(irq === 1'b1, "R6 irq after enable", 32'(irq), 1);
      wr(A_PER, 32'd0);
      wr(A_ACK, 32'h3);
      wr(A_ACK, 32'h0);
      for (int i = 0; i < 5; i++) serve_next("R3 period zero");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ring();
      t_pause();
      t_clear();
      t_init();
      t_poll();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule